// File: doc/BRIEF.md
# Highway and Farm-Road Junction Light Sequencer

This block sequences the signal lamps at a crossing between a busy highway and a lightly used farm road. The highway is the default owner of the junction. Its green phase ends only after a vehicle has been sensed on the farm road and a guaranteed minimum highway green has run out. The farm road then gets a green phase. That phase ends as soon as no farm vehicle remains, or when the maximum farm green runs out, whichever happens first. A yellow phase of fixed length separates each green from the following red.

All timing comes from one restartable cycle counter. The counter restarts on every phase change and saturates at the long interval. It provides a short-interval flag, which sets the yellow length, and a long-interval flag, which sets both the minimum highway green and the maximum farm green. Both lamp outputs are registered Moore outputs that depend only on the current phase.

The reset input is asynchronous and active low. It is released to the logic through a two-stage synchronizer, so the lamps return to highway green at once when reset is asserted.

Top module: `tlc_junction_ctrl`

## Requirements
- R1: While `rst_n` is low, the highway lamp shows green (00) and the farm lamp shows red (10), starting at once and without waiting for a clock edge.
- R2: While `farm_car` is low, the highway-green phase holds for any number of cycles.
- R3: When `farm_car` is high, a highway-green phase lasts exactly `LONG_CYC` cycles and is then followed by highway yellow. Any highway green that starts from reset or after farm yellow lasts at least `LONG_CYC` cycles.
- R4: Highway yellow (highway 01, farm 10) lasts exactly `SHORT_CYC` cycles for either value of `farm_car`, and is then followed by farm green.
- R5: With `farm_car` held high, farm green (highway 10, farm 00) lasts exactly `LONG_CYC` cycles. It never lasts longer.
- R6: If `farm_car` is sampled low in a farm-green cycle, farm yellow starts in the next cycle.
- R7: Farm yellow (highway 10, farm 01) lasts exactly `SHORT_CYC` cycles and is then followed by highway green.
- R8: Each lamp uses the code 00 for green, 01 for yellow and 10 for red. The code 11 never appears.
- R9: At least one of the two lamps shows red in every cycle.
- R10: The interval counter restarts at 1 on every phase change and saturates at `LONG_CYC`. If `farm_car` first rises after the highway green has already lasted `LONG_CYC` cycles, highway yellow starts in the cycle after `farm_car` is first sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| farm_car | input | 1 | Vehicle present on the farm road |
| hwy_lamp | output | 2 | Highway lamp code (00 green, 01 yellow, 10 red) |
| farm_lamp | output | 2 | Farm-road lamp code (00 green, 01 yellow, 10 red) |

## Verification
The lamps come from the phase register. A change of phase therefore shows on the lamps one cycle after the rising edge that samples the deciding condition. That condition is `farm_car` together with a timer flag. The one exception is reset, which acts on the lamps at once.

The bench changes `farm_car` only at falling edges, so the next rising edge sees the new value. It measures each phase by counting falling edges from the first falling edge on which the new lamp pair appears. A phase that the requirements fix at N cycles must therefore show exactly N samples. A change of `farm_car` during cycle k of a farm green must end that phase after exactly k samples. The one asynchronous case, reset, is sampled one time unit after `rst_n` falls, before any clock edge can occur.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  // Phase codes are chosen so that every legal transition flips one bit.
  typedef enum logic [1:0] {
    PH_HWY_GO    = 2'b00,
    PH_HWY_WARN  = 2'b01,
    PH_FARM_GO   = 2'b11,
    PH_FARM_WARN = 2'b10
  } phase_e;

  typedef enum logic [1:0] {
    LAMP_GREEN  = 2'b00,
    LAMP_YELLOW = 2'b01,
    LAMP_RED    = 2'b10
  } lamp_e;

  localparam int unsigned NUM_ROADS = 2;
  localparam int unsigned ROAD_HWY  = 0;
  localparam int unsigned ROAD_FARM = 1;

endpackage

// File: rtl/tlc_rst_sync.sv
module tlc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/tlc_interval_timer.sv
module tlc_interval_timer #(
  parameter int unsigned SHORT_CYC = 4,
  parameter int unsigned LONG_CYC  = 12,
  localparam int unsigned CW = $clog2(LONG_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] cnt,
  output logic          short_done,
  output logic          long_done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // The count is the number of cycles spent in the current phase, this cycle included.
  always_comb begin
    cnt_en = restart || (cnt_q < CW'(LONG_CYC));
    cnt_d  = restart ? CW'(1) : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(1);
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt        = cnt_q;
  assign short_done = (cnt_q >= CW'(SHORT_CYC));
  assign long_done  = (cnt_q >= CW'(LONG_CYC));

endmodule

// File: rtl/tlc_phase_seq.sv
module tlc_phase_seq
  import tlc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   farm_car,
  input  logic   short_done,
  input  logic   long_done,
  output phase_e phase,
  output logic   restart
);

  phase_e phase_q;
  phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_HWY_GO:    if (farm_car && long_done)    phase_d = PH_HWY_WARN;
      PH_HWY_WARN:  if (short_done)               phase_d = PH_FARM_GO;
      PH_FARM_GO:   if (!farm_car || long_done)   phase_d = PH_FARM_WARN;
      PH_FARM_WARN: if (short_done)               phase_d = PH_HWY_GO;
      default:                                    phase_d = PH_HWY_GO;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HWY_GO;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign phase   = phase_q;
  assign restart = (phase_d != phase_q);

endmodule

// File: rtl/tlc_lamp_decode.sv
module tlc_lamp_decode
  import tlc_pkg::*;
#(
  parameter int unsigned ROAD = ROAD_HWY
) (
  input  phase_e phase,
  output lamp_e  lamp
);

  localparam phase_e GO_PH   = (ROAD == ROAD_FARM) ? PH_FARM_GO   : PH_HWY_GO;
  localparam phase_e WARN_PH = (ROAD == ROAD_FARM) ? PH_FARM_WARN : PH_HWY_WARN;

  always_comb begin
    if (phase == GO_PH) begin
      lamp = LAMP_GREEN;
    end else if (phase == WARN_PH) begin
      lamp = LAMP_YELLOW;
    end else begin
      lamp = LAMP_RED;
    end
  end

endmodule

// File: rtl/tlc_junction_ctrl.sv
module tlc_junction_ctrl
  import tlc_pkg::*;
#(
  parameter int unsigned SHORT_CYC = 4,
  parameter int unsigned LONG_CYC  = 12,
  localparam int unsigned CW = $clog2(LONG_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       farm_car,
  output logic [1:0] hwy_lamp,
  output logic [1:0] farm_lamp
);

  logic          rst_sync_n;
  logic          restart_w;
  logic          ts_w;
  logic          tl_w;
  logic [CW-1:0] cnt_w;
  phase_e        phase_w;
  lamp_e         lamp_w [NUM_ROADS];

  tlc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tlc_interval_timer #(
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .restart    (restart_w),
    .cnt        (cnt_w),
    .short_done (ts_w),
    .long_done  (tl_w)
  );

  tlc_phase_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .farm_car   (farm_car),
    .short_done (ts_w),
    .long_done  (tl_w),
    .phase      (phase_w),
    .restart    (restart_w)
  );

  for (genvar r = 0; r < NUM_ROADS; r++) begin : g_road
    tlc_lamp_decode #(.ROAD(r)) u_dec (
      .phase (phase_w),
      .lamp  (lamp_w[r])
    );
  end

  assign hwy_lamp  = lamp_w[ROAD_HWY];
  assign farm_lamp = lamp_w[ROAD_FARM];

endmodule

// File: rtl/tlc_junction_chk.sv
module tlc_junction_chk
  import tlc_pkg::*;
#(
  parameter int unsigned SHORT_CYC = 4,
  parameter int unsigned LONG_CYC  = 12,
  localparam int unsigned CW = $clog2(LONG_CYC + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          farm_car,
  input phase_e        phase,
  input logic          restart,
  input logic [CW-1:0] cnt,
  input logic          ts,
  input logic          tl,
  input logic [1:0]    hwy_lamp,
  input logic [1:0]    farm_lamp
);

  p_hg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HWY_GO && !(farm_car && tl)) |=> (phase == PH_HWY_GO));

  p_hg_leave_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HWY_GO && farm_car && tl) |=> (phase == PH_HWY_WARN));

  p_hy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HWY_WARN && !ts) |=> (phase == PH_HWY_WARN));

  p_hy_leave_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HWY_WARN && ts) |=> (phase == PH_FARM_GO));

  p_fg_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FARM_GO && tl) |=> (phase == PH_FARM_WARN));

  p_fg_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FARM_GO && !farm_car) |=> (phase == PH_FARM_WARN));

  p_fy_leave_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FARM_WARN && ts) |=> (phase == PH_HWY_GO));

  p_lamp_codes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hwy_lamp != 2'b11) && (farm_lamp != 2'b11));

  p_one_red_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hwy_lamp == LAMP_RED) || (farm_lamp == LAMP_RED));

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == CW'(1)));

  p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(LONG_CYC) && !restart) |=> (cnt == CW'(LONG_CYC)));

endmodule

bind tlc_junction_ctrl tlc_junction_chk #(
  .SHORT_CYC (SHORT_CYC),
  .LONG_CYC  (LONG_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .farm_car  (farm_car),
  .phase     (phase_w),
  .restart   (restart_w),
  .cnt       (cnt_w),
  .ts        (ts_w),
  .tl        (tl_w),
  .hwy_lamp  (hwy_lamp),
  .farm_lamp (farm_lamp)
);

// File: tb/tlc_junction_ctrl_tb.sv
module tlc_junction_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SHORT_T    = 4;
  localparam int LONG_T     = 12;
  localparam logic [1:0] GRN = 2'b00;
  localparam logic [1:0] YEL = 2'b01;
  localparam logic [1:0] RED = 2'b10;

  typedef struct packed {
    logic       c0;
    logic [7:0] flip_at;
    logic [1:0] h;
    logic [1:0] f;
    logic [7:0] len;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 8'd0,          YEL, RED, 8'(SHORT_T), 4'd4},  // R4
    '{1'b1, 8'd0,          RED, GRN, 8'(LONG_T),  4'd5},  // R5
    '{1'b1, 8'd0,          RED, YEL, 8'(SHORT_T), 4'd7},  // R7
    '{1'b1, 8'd0,          GRN, RED, 8'(LONG_T),  4'd3},  // R3
    '{1'b0, 8'd0,          YEL, RED, 8'(SHORT_T), 4'd4},  // R4
    '{1'b0, 8'd0,          RED, GRN, 8'd1,        4'd6},  // R6
    '{1'b0, 8'd0,          RED, YEL, 8'(SHORT_T), 4'd7},  // R7
    '{1'b0, 8'd20,         GRN, RED, 8'd20,       4'd10}, // R10
    '{1'b1, 8'd0,          YEL, RED, 8'(SHORT_T), 4'd4},  // R4
    '{1'b1, 8'd5,          RED, GRN, 8'd5,        4'd6},  // R6
    '{1'b1, 8'd0,          RED, YEL, 8'(SHORT_T), 4'd7},  // R7
    '{1'b0, 8'd3,          GRN, RED, 8'(LONG_T),  4'd3},  // R3
    '{1'b1, 8'd0,          YEL, RED, 8'(SHORT_T), 4'd4},  // R4
    '{1'b1, 8'd0,          RED, GRN, 8'(LONG_T),  4'd5},  // R5
    '{1'b0, 8'd0,          RED, YEL, 8'(SHORT_T), 4'd7},  // R7
    '{1'b0, 8'(LONG_T),    GRN, RED, 8'(LONG_T),  4'd3}   // R3
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       farm_car = 1'b0;
  logic [1:0] hwy_lamp;
  logic [1:0] farm_lamp;

  int  checks = 0;
  int  fails  = 0;
  int  r9_bad = 0;
  bit  done   = 1'b0;

  tlc_junction_ctrl #(.SHORT_CYC(SHORT_T), .LONG_CYC(LONG_T)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .farm_car  (farm_car),
    .hwy_lamp  (hwy_lamp),
    .farm_lamp (farm_lamp)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && hwy_lamp != RED && farm_lamp != RED) r9_bad++;
  end

  task automatic check_val(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Called at the first falling edge of a phase; returns at the first falling edge of the next one.
  task automatic run_phase(input vec_t v, input int idx);
    int n;
    n = 0;
    farm_car = v.c0;
    if (hwy_lamp == v.h && farm_lamp == v.f) begin
      n = 1;
      if (v.flip_at == 8'd1) farm_car = ~v.c0;
      for (int k = 0; k < 250; k++) begin
        @(negedge clk);
        if (hwy_lamp == v.h && farm_lamp == v.f) begin
          n++;
          if (n == int'(v.flip_at)) farm_car = ~v.c0;
        end else begin
          break;
        end
      end
    end
    checks++;
    if (n != int'(v.len)) begin
      fails++;
      $display("FAIL R%0d row %0d lamps %b/%b: actual length %0d expected %0d",
               v.req, idx, v.h, v.f, n, v.len);
    end
  endtask

  initial begin
    int hold_ok;
    int hg_len;
    repeat (3) @(negedge clk);
    // R1: reset state before release
    check_val("R1", int'({hwy_lamp, farm_lamp}), int'({GRN, RED}), "lamps in reset");
    rst_n = 1'b1;
    // R2: no farm vehicle keeps highway green
    hold_ok = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (hwy_lamp == GRN && farm_lamp == RED) hold_ok++;
    end
    check_val("R2", hold_ok, 30, "highway green cycles with no vehicle");
    // R10: timer saturated, so the vehicle ends highway green after one sample
    farm_car = 1'b1;
    @(negedge clk);
    check_val("R10", int'({hwy_lamp, farm_lamp}), int'({YEL, RED}), "lamps one cycle after late vehicle");
    for (int i = 0; i < NV; i++) run_phase(TBL[i], i);
    // Now in highway yellow; advance to farm green and reset asynchronously there
    run_phase(TBL[0], 100);
    #1 rst_n = 1'b0;
    #1 check_val("R1", int'({hwy_lamp, farm_lamp}), int'({GRN, RED}), "lamps after async reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3: highway green after reset lasts at least LONG with vehicle waiting
    hg_len = 0;
    for (int k = 0; k < 250; k++) begin
      if (hwy_lamp == GRN && farm_lamp == RED) hg_len++;
      else break;
      @(negedge clk);
    end
    checks++;
    if (hg_len < LONG_T || hwy_lamp != YEL) begin
      fails++;
      $display("FAIL R3 green after reset: actual %0d cycles then %b expected >= %0d then %b",
               hg_len, hwy_lamp, LONG_T, YEL);
    end
    check_val("R9", r9_bad, 0, "cycles with no red lamp");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule